// File: doc/BRIEF.md
# PCM Channel Level Meter

This block measures how loud one PCM channel is. The channel is chosen from a group of eight channels that share the meter. Sample words arrive one at a time, each with a valid strobe and the index of the channel it belongs to. While metering is enabled, every sample from the selected channel is turned into a magnitude and added to an internal sum. In linear mode the sample is a 16-bit two's complement word. In compressed mode its low byte is a mu-law code that is first expanded to linear.

After a programmed number of selected samples, the sum is captured into two 8-bit result registers and a ready flag is raised. The sum then starts again from zero. A host reads the result through the two register outputs. A read strobe on the high register tells the block that the high part has been read, and this clears the flag. A newer result replaces an older one whether or not the older one was read.

Top module: `pcm_level_meter`

## Requirements
- R1: After a synchronous reset, both result outputs are zero and the ready flag is clear.
- R2: A sample is added only when the enable is high and its channel index equals the select field. Strobes from other channels leave the sum and the results untouched.
- R3: When lin_mode_i is 1, the sample is 16-bit two's complement and its absolute value is added. For example, -200 adds 200.
- R4: When lin_mode_i is 0, only bits [7:0] are used, as a mu-law code. Call the inverted code c. The exponent e is c[6:4] and the mantissa m is c[3:0]. The magnitude is ((8*m + 132) << e) - 132, and the sign bit c[7] is dropped. Bits [15:8] are ignored.
- R5: A measurement covers N selected samples, where N is count_i, and a count of 0 acts as 1. The result outputs change in the same clock edge that accepts the Nth sample.
- R6: res_lo_o carries the ready flag in bit 7 and result bits [6:0] in bits [6:0]. res_hi_o carries result bits [14:7].
- R7: A pulse on rd_hi_i clears the ready flag and leaves the result bits as they are. A pulse on rd_lo_i changes nothing. If a new result is captured in the same cycle as rd_hi_i, the flag ends up set.
- R8: Each new result overwrites both registers even when the previous one was not read.
- R9: The 15-bit sum saturates at 32767 instead of wrapping.
- R10: The sum and the sample count return to zero in four cases: after each capture, when the enable changes, when the select changes, and while metering is disabled. A sample that arrives on the edge where such a change is first seen is discarded. Results are held while metering is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | Sample strobe, one cycle per sample |
| smp_ch_i | input | 3 | Channel index of the sample |
| smp_data_i | input | 16 | Sample word, linear or mu-law in the low byte |
| en_i | input | 1 | Metering enable |
| sel_i | input | 3 | Channel to measure |
| lin_mode_i | input | 1 | 1 = linear samples, 0 = mu-law samples |
| count_i | input | 8 | Selected samples per measurement |
| rd_lo_i | input | 1 | Host read strobe of the low result register |
| rd_hi_i | input | 1 | Host read strobe of the high result register |
| res_lo_o | output | 8 | Ready flag and low 7 result bits |
| res_hi_o | output | 8 | High 8 result bits |

## Verification
The hardest situations to reach from the ports come in two groups. The first is a restart partway through a measurement: the select or the enable changes after some samples have already been summed, and the next result must hold only the samples taken after the change. The stimulus creates this by feeding part of a measurement, reconfiguring, and then finishing a full measurement whose expected sum cannot match if the stale part leaked in. The second is a capture that coincides with a high-register read. The bench raises the read strobe in the very cycle that carries the last sample of a measurement.

// File: rtl/lvlm_pkg.sv
package lvlm_pkg;

    localparam int SMP_W   = 16;
    localparam int CODE_W  = 8;
    localparam int RES_W   = 15;
    localparam int LO_W    = 7;
    localparam int HI_W    = RES_W - LO_W;
    localparam int MU_BIAS = 132;
    localparam int MU_MAX  = 32124;
    localparam logic [RES_W-1:0] RES_MAX = '1;

    typedef enum logic {
        MODE_COMP   = 1'b0,
        MODE_LINEAR = 1'b1
    } smp_mode_e;

    typedef struct packed {
        logic             vld;
        logic [SMP_W-1:0] mag;
    } mag_t;

    typedef struct packed {
        logic             vld;
        logic [RES_W-1:0] val;
    } res_t;

    function automatic logic [SMP_W-1:0] mu_expand(input logic [CODE_W-1:0] code);
        logic [CODE_W-1:0] c;
        logic [SMP_W-1:0]  base;
        c    = ~code;
        base = {{(SMP_W-7){1'b0}}, c[3:0], 3'b000} + SMP_W'(MU_BIAS);
        return (base << c[6:4]) - SMP_W'(MU_BIAS);
    endfunction

    function automatic logic [SMP_W-1:0] lin_abs(input logic [SMP_W-1:0] s);
        return s[SMP_W-1] ? (~s + 1'b1) : s;
    endfunction

    function automatic logic [RES_W-1:0] sat_add(input logic [RES_W-1:0] acc,
                                                 input logic [SMP_W-1:0] mag);
        logic [SMP_W:0] s;
        s = {{(SMP_W+1-RES_W){1'b0}}, acc} + {1'b0, mag};
        return (s > {{(SMP_W+1-RES_W){1'b0}}, RES_MAX}) ? RES_MAX : s[RES_W-1:0];
    endfunction

endpackage

// File: rtl/lvlm_rectify.sv
module lvlm_rectify
    import lvlm_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             smp_vld_i,
    input  logic [CH_W-1:0]  smp_ch_i,
    input  logic [SMP_W-1:0] smp_data_i,
    input  logic             en_i,
    input  logic [CH_W-1:0]  sel_i,
    input  smp_mode_e        mode_i,
    output mag_t             mag_o
);

    logic [SMP_W-1:0] mu_mag;
    logic [SMP_W-1:0] lin_mag;

    always_comb begin
        mu_mag    = mu_expand(smp_data_i[CODE_W-1:0]);
        lin_mag   = lin_abs(smp_data_i);
        mag_o.vld = smp_vld_i && en_i && (smp_ch_i == sel_i);
        mag_o.mag = (mode_i == MODE_LINEAR) ? lin_mag : mu_mag;
    end

    // Expanded mu-law magnitude never exceeds the largest code value.
    always_ff @(posedge clk_i) begin
        if (!rst_i && smp_vld_i && mode_i == MODE_COMP)
            assert_mu_range_R4: assert (mu_mag <= SMP_W'(MU_MAX));
    end

endmodule

// File: rtl/lvlm_accum.sv
module lvlm_accum
    import lvlm_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [CH_W-1:0]  sel_i,
    input  logic [CNT_W-1:0] count_i,
    input  mag_t             mag_i,
    output res_t             latch_o
);

    logic [RES_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             en_q;
    logic [CH_W-1:0]  sel_q;
    logic             restart;
    logic [CNT_W-1:0] cnt_lim;
    logic             last;
    logic [RES_W-1:0] sum;

    always_comb begin
        restart     = !en_i || (en_i != en_q) || (sel_i != sel_q);
        cnt_lim     = (count_i == '0) ? CNT_W'(1) : count_i;
        last        = ({1'b0, cnt_q} + 1'b1) >= {1'b0, cnt_lim};
        sum         = sat_add(acc_q, mag_i.mag);
        latch_o.vld = !restart && mag_i.vld && last;
        latch_o.val = sum;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q <= '0;
            cnt_q <= '0;
            en_q  <= 1'b0;
            sel_q <= '0;
        end else begin
            en_q  <= en_i;
            sel_q <= sel_i;
            if (restart) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else if (mag_i.vld) begin
                if (last) begin
                    acc_q <= '0;
                    cnt_q <= '0;
                end else begin
                    acc_q <= sum;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // Accumulation never wraps downward within a measurement.
    assert_acc_no_wrap_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (mag_i.vld && !restart && !last) |=> (acc_q >= $past(acc_q)));

    // A capture starts the next measurement from zero.
    assert_restart_after_latch_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        latch_o.vld |=> (acc_q == '0 && cnt_q == '0));

    // Disabling the meter empties the sum.
    assert_disable_clears_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (acc_q == '0));

endmodule

// File: rtl/lvlm_result.sv
module lvlm_result
    import lvlm_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_i,
    input  res_t            latch_i,
    input  logic            rd_lo_i,
    input  logic            rd_hi_i,
    output logic [LO_W:0]   res_lo_o,
    output logic [HI_W-1:0] res_hi_o
);

    logic [RES_W-1:0] res_q;
    logic             rdy_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            res_q <= '0;
            rdy_q <= 1'b0;
        end else if (latch_i.vld) begin
            res_q <= latch_i.val;
            rdy_q <= 1'b1;
        end else if (rd_hi_i) begin
            rdy_q <= 1'b0;
        end
    end

    assign res_lo_o = {rdy_q, res_q[LO_W-1:0]};
    assign res_hi_o = res_q[RES_W-1:LO_W];

    // Both halves and the flag are updated together, overwriting old data.
    assert_latch_both_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        latch_i.vld |=> (rdy_q && res_q == $past(latch_i.val)));

    // A high read with no new capture clears the flag.
    assert_rd_hi_clears_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_hi_i && !latch_i.vld) |=> !rdy_q);

    // A low read alone leaves flag and data alone.
    assert_rd_lo_inert_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_lo_i && !rd_hi_i && !latch_i.vld) |=> ($stable(rdy_q) && $stable(res_q)));

endmodule

// File: rtl/pcm_level_meter.sv
module pcm_level_meter
    import lvlm_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             smp_vld_i,
    input  logic [CH_W-1:0]  smp_ch_i,
    input  logic [15:0]      smp_data_i,
    input  logic             en_i,
    input  logic [CH_W-1:0]  sel_i,
    input  logic             lin_mode_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             rd_lo_i,
    input  logic             rd_hi_i,
    output logic [7:0]       res_lo_o,
    output logic [7:0]       res_hi_o
);

    mag_t      mag;
    res_t      latch;
    smp_mode_e mode;

    assign mode = smp_mode_e'(lin_mode_i);

    lvlm_rectify #(.CH_W(CH_W)) u_rect (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .smp_vld_i  (smp_vld_i),
        .smp_ch_i   (smp_ch_i),
        .smp_data_i (smp_data_i),
        .en_i       (en_i),
        .sel_i      (sel_i),
        .mode_i     (mode),
        .mag_o      (mag)
    );

    lvlm_accum #(.CH_W(CH_W), .CNT_W(CNT_W)) u_acc (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (en_i),
        .sel_i   (sel_i),
        .count_i (count_i),
        .mag_i   (mag),
        .latch_o (latch)
    );

    lvlm_result u_res (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .latch_i  (latch),
        .rd_lo_i  (rd_lo_i),
        .rd_hi_i  (rd_hi_i),
        .res_lo_o (res_lo_o),
        .res_hi_o (res_hi_o)
    );

endmodule

// File: tb/pcm_level_meter_tb.sv
module pcm_level_meter_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        vld, en, lin, rd_lo, rd_hi;
    logic [2:0]  ch, sel;
    logic [15:0] data;
    logic [7:0]  cnt;
    logic [7:0]  lo, hi;
    int          n_chk = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    pcm_level_meter dut_i (
        .clk_i(clk), .rst_i(rst), .smp_vld_i(vld), .smp_ch_i(ch), .smp_data_i(data),
        .en_i(en), .sel_i(sel), .lin_mode_i(lin), .count_i(cnt),
        .rd_lo_i(rd_lo), .rd_hi_i(rd_hi), .res_lo_o(lo), .res_hi_o(hi)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] c, input logic [15:0] d, input logic rh);
        @(negedge clk);
        vld = 1'b1; ch = c; data = d; rd_hi = rh;
        @(negedge clk);
        vld = 1'b0; rd_hi = 1'b0;
    endtask

    task automatic setcfg(input logic e, input logic [2:0] s, input logic l, input logic [7:0] n);
        @(negedge clk);
        en = e; sel = s; lin = l; cnt = n;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_hi();
        @(negedge clk); rd_hi = 1'b1;
        @(negedge clk); rd_hi = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 lo", lo, 8'h00);
        check("R1 hi", hi, 8'h00);
    endtask

    task automatic t_linear();
        setcfg(1, 3'd2, 1, 8'd3);
        send(3'd2, 16'd100, 0);
        send(3'd2, -16'sd200, 0);
        check("R5 not ready before N", lo, 8'h00);
        send(3'd2, 16'd300, 0);
        check("R3 R6 lo", lo, 8'hD8);   // 600: ready, 0x58
        check("R3 R6 hi", hi, 8'h04);
    endtask

    task automatic t_read();
        @(negedge clk); rd_lo = 1'b1;
        @(negedge clk); rd_lo = 1'b0;
        check("R7 rd_lo inert", lo, 8'hD8);
        read_hi();
        check("R7 rd_hi clears ready", lo, 8'h58);
        check("R7 data held", hi, 8'h04);
    endtask

    task automatic t_channel();
        setcfg(1, 3'd5, 1, 8'd2);
        send(3'd5, 16'd40, 0);
        send(3'd1, 16'd9999, 0);
        send(3'd0, -16'sd5000, 0);
        check("R2 other channels ignored", lo, 8'h58);
        send(3'd5, -16'sd60, 0);
        check("R2 lo", lo, 8'hE4);      // 100
        check("R2 hi", hi, 8'h00);
    endtask

    task automatic t_overwrite();
        setcfg(1, 3'd5, 1, 8'd1);
        send(3'd5, 16'd5, 0);
        check("R8 first", lo, 8'h85);
        send(3'd5, 16'd9, 0);
        check("R8 overwrite, R10 restart after latch", lo, 8'h89);
    endtask

    task automatic t_count0();
        setcfg(1, 3'd5, 1, 8'd0);
        send(3'd5, 16'd7, 0);
        check("R5 count 0 acts as 1", lo, 8'h87);
    endtask

    task automatic t_mulaw();
        setcfg(1, 3'd1, 0, 8'd4);
        send(3'd1, 16'hABFF, 0);        // 0
        send(3'd1, 16'h12FE, 0);        // 8
        send(3'd1, 16'h00EF, 0);        // 132
        send(3'd1, 16'hFF8F, 0);        // 16764
        check("R4 lo", lo, 8'h88);      // 16904
        check("R4 hi", hi, 8'h84);
        setcfg(1, 3'd1, 0, 8'd1);
        send(3'd1, 16'h007F, 0);        // negative zero
        check("R4 sign dropped zero", lo, 8'h80);
    endtask

    task automatic t_sat();
        setcfg(1, 3'd6, 1, 8'd2);
        send(3'd6, 16'd30000, 0);
        send(3'd6, -16'sd30000, 0);
        check("R9 sat lo", lo, 8'hFF);
        check("R9 sat hi", hi, 8'hFF);
        setcfg(1, 3'd6, 1, 8'd1);
        send(3'd6, 16'h8000, 0);
        check("R3 R9 most negative", hi, 8'hFF);
    endtask

    task automatic t_restart();
        setcfg(1, 3'd2, 1, 8'd3);
        send(3'd2, 16'd1000, 0);
        send(3'd2, 16'd1000, 0);
        setcfg(1, 3'd4, 1, 8'd3);
        for (int i = 0; i < 3; i++) send(3'd4, 16'd10, 0);
        check("R10 select change restarts lo", lo, 8'h9E);
        check("R10 select change restarts hi", hi, 8'h00);
        read_hi();
        send(3'd4, 16'd500, 0);
        setcfg(0, 3'd4, 1, 8'd3);
        for (int i = 0; i < 3; i++) send(3'd4, 16'd7000, 0);
        check("R10 disabled holds lo", lo, 8'h1E);
        check("R10 disabled holds hi", hi, 8'h00);
        setcfg(1, 3'd4, 1, 8'd3);
        for (int i = 0; i < 3; i++) send(3'd4, 16'd10, 0);
        check("R10 enable restarts", lo, 8'h9E);
        check("R10 enable restarts hi", hi, 8'h00);
    endtask

    task automatic t_priority();
        read_hi();
        setcfg(1, 3'd4, 1, 8'd1);
        send(3'd4, 16'd3, 1);
        check("R7 capture beats rd_hi", lo, 8'h83);
    endtask

    initial begin
        rst = 1'b1; vld = 0; en = 0; lin = 1; rd_lo = 0; rd_hi = 0;
        ch = 0; sel = 0; data = 0; cnt = 8'd1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_linear();
        t_read();
        t_channel();
        t_overwrite();
        t_count0();
        t_mulaw();
        t_sat();
        t_restart();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule